// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the data-memory operand address of one instruction from a selected addressing mode, a base register value, an index register value, a sign-extended immediate and a step code. Where the mode updates its base register, it also drives a register writeback port carrying the new base value. The register file and the data memory sit outside the block.

A request is made by pulsing `start_i` with the operands. All modes but one return their result one cycle later. Memory-indirect mode first issues a pointer read at the base address, then waits for the memory's acknowledge, and finally presents the fetched word as the operand address. The step code `step_i` selects d = 1 << `step_i`, so d is 1, 2, 4 or 8. That one value serves both as the scale in scaled-index mode and as the step in the auto-modify modes.

Top module: `ea_gen`

## Requirements
- R1: While reset is applied, and afterwards until the first request, `ea_valid_o`, `ptr_rd_o`, `busy_o` and `wb_en_o` are all 0.
- R2: Mode code 0 (register indirect) gives the address `base_i`. Mode code 1 (absolute) gives `imm_i` sign-extended to ADDR_W.
- R3: Mode code 2 (displacement) gives `base_i` plus sign-extended `imm_i`. Mode code 3 (indexed) gives `base_i + index_i`. All sums wrap modulo 2^ADDR_W.
- R4: Mode code 4 (scaled) gives sign-extended `imm_i` + `base_i` + (`index_i` << `step_i`), which covers scale factors 1, 2, 4 and 8.
- R5: Every mode except mode 5 presents its result on `ea_o`, with `ea_valid_o` high for exactly one cycle, on the cycle after the one in which `start_i` is sampled high while the block is idle.
- R6: Mode code 5 (memory indirect) behaves as follows. In the cycle after the request, `ptr_rd_o` and `busy_o` are high and `ea_o` equals `base_i`. Both stay high until the cycle in which `ptr_ack_i` is high, and that cycle is included. In the next cycle `busy_o` is low, `ea_valid_o` is high and `ea_o` equals the `ptr_data_i` value that was sampled with the acknowledge.
- R7: While `busy_o` is high, `start_i` is ignored: no result is produced and `ea_o` does not change.
- R8: Mode code 6 (autoincrement) gives the address `base_i`, with `wb_en_o` high and `wb_data_o = base_i + d`.
- R9: Mode code 7 (autodecrement) gives the address `base_i - d`, with `wb_en_o` high and `wb_data_o` equal to that same value.
- R10: `wb_en_o` is high only in the result cycle of a mode 6 or mode 7 request. It is low for every other mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| base_i | input | ADDR_W | Base register value |
| index_i | input | ADDR_W | Index register value |
| imm_i | input | IMM_W | Immediate / displacement, signed |
| step_i | input | 2 | Step code, d = 1 << step_i |
| ptr_data_i | input | ADDR_W | Pointer word returned by memory |
| ptr_ack_i | input | 1 | Pointer read complete |
| ea_o | output | ADDR_W | Effective address (pointer address while ptr_rd_o) |
| ea_valid_o | output | 1 | Final address valid |
| ptr_rd_o | output | 1 | Indirect pointer read request |
| busy_o | output | 1 | Memory-indirect access in progress |
| wb_en_o | output | 1 | Base register write enable |
| wb_data_o | output | ADDR_W | Updated base register value |

## Verification
The assertions assume that `ptr_ack_i` is raised only while `busy_o` is high. They also assume that the operand inputs stay stable only in the cycle in which `start_i` is sampled, because each result is checked against the values `$past` returns. The stimulus drives the acknowledge solely inside the pointer wait, after a random delay. During that wait it keeps asserting `start_i` with other random operands, which tests that the block ignores them. Random requests cover all eight mode codes and all four step codes, and directed cases add wrap-around sums, negative immediates and an acknowledge on the very first wait cycle.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    M_REG_IND = 3'd0,
    M_ABS     = 3'd1,
    M_DISP    = 3'd2,
    M_INDEXED = 3'd3,
    M_SCALED  = 3'd4,
    M_MEM_IND = 3'd5,
    M_AUTOINC = 3'd6,
    M_AUTODEC = 3'd7
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PTR  = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_shift.sv
module ea_shift #(
  parameter int unsigned W      = 32,
  parameter int unsigned STEP_W = 2
) (
  input  logic [W-1:0]      val_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [W-1:0]      shifted_o,
  output logic [W-1:0]      d_o
);
  localparam int unsigned N_STEP = 1 << STEP_W;

  logic [W-1:0] sh_opts [N_STEP];
  logic [W-1:0] d_opts  [N_STEP];

  for (genvar g = 0; g < N_STEP; g++) begin : g_opt
    assign sh_opts[g] = val_i << g;
    assign d_opts[g]  = W'(1) << g;
  end

  assign shifted_o = sh_opts[step_i];
  assign d_o       = d_opts[step_i];
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned STEP_W = 2
) (
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_data_o
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_x, idx_sh, d_val, base_inc, base_dec;

  assign imm_x = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  ea_shift #(.W(ADDR_W), .STEP_W(STEP_W)) u_shift (
    .val_i     (index_i),
    .step_i    (step_i),
    .shifted_o (idx_sh),
    .d_o       (d_val)
  );

  assign base_inc = base_i + d_val;
  assign base_dec = base_i - d_val;

  always_comb begin
    ea_o      = base_i;
    wb_en_o   = 1'b0;
    wb_data_o = base_inc;
    unique case (ea_mode_e'(mode_i))
      M_REG_IND: ea_o = base_i;
      M_ABS:     ea_o = imm_x;
      M_DISP:    ea_o = base_i + imm_x;
      M_INDEXED: ea_o = base_i + index_i;
      M_SCALED:  ea_o = imm_x + base_i + idx_sh;
      M_MEM_IND: ea_o = base_i;  // pointer address
      M_AUTOINC: begin
        ea_o      = base_i;
        wb_en_o   = 1'b1;
        wb_data_o = base_inc;
      end
      M_AUTODEC: begin
        ea_o      = base_dec;
        wb_en_o   = 1'b1;
        wb_data_o = base_dec;
      end
      default:   ea_o = base_i;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_ind_i,
  input  logic [ADDR_W-1:0] calc_ea_i,
  input  logic              calc_wb_en_i,
  input  logic [ADDR_W-1:0] calc_wb_i,
  input  logic [ADDR_W-1:0] ptr_data_i,
  input  logic              ptr_ack_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_valid_o,
  output logic              ptr_rd_o,
  output logic              busy_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_data_o
);
  ea_state_e         st_q;
  logic [ADDR_W-1:0] ea_q, wb_q;
  logic              vld_q, wb_en_q, ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ea_q    <= '0;
      wb_q    <= '0;
      vld_q   <= 1'b0;
      wb_en_q <= 1'b0;
      ptr_q   <= 1'b0;
    end else begin
      vld_q   <= 1'b0;
      wb_en_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            ea_q <= calc_ea_i;
            if (is_ind_i) begin
              st_q  <= ST_PTR;
              ptr_q <= 1'b1;
            end else begin
              vld_q   <= 1'b1;
              wb_en_q <= calc_wb_en_i;
              wb_q    <= calc_wb_i;
            end
          end
        end
        ST_PTR: begin
          if (ptr_ack_i) begin
            st_q  <= ST_IDLE;
            ptr_q <= 1'b0;
            ea_q  <= ptr_data_i;
            vld_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ea_o       = ea_q;
  assign ea_valid_o = vld_q;
  assign ptr_rd_o   = ptr_q;
  assign busy_o     = (st_q == ST_PTR);
  assign wb_en_o    = wb_en_q;
  assign wb_data_o  = wb_q;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        step_i,
  input  logic [ADDR_W-1:0] ptr_data_i,
  input  logic              ptr_ack_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_valid_o,
  output logic              ptr_rd_o,
  output logic              busy_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_data_o
);
  logic [ADDR_W-1:0] calc_ea, calc_wb;
  logic              calc_wb_en, is_ind;

  assign is_ind = (ea_mode_e'(mode_i) == M_MEM_IND);

  ea_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .STEP_W(2)) u_calc (
    .mode_i    (mode_i),
    .base_i    (base_i),
    .index_i   (index_i),
    .imm_i     (imm_i),
    .step_i    (step_i),
    .ea_o      (calc_ea),
    .wb_en_o   (calc_wb_en),
    .wb_data_o (calc_wb)
  );

  ea_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .is_ind_i     (is_ind),
    .calc_ea_i    (calc_ea),
    .calc_wb_en_i (calc_wb_en),
    .calc_wb_i    (calc_wb),
    .ptr_data_i   (ptr_data_i),
    .ptr_ack_i    (ptr_ack_i),
    .ea_o         (ea_o),
    .ea_valid_o   (ea_valid_o),
    .ptr_rd_o     (ptr_rd_o),
    .busy_o       (busy_o),
    .wb_en_o      (wb_en_o),
    .wb_data_o    (wb_data_o)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [1:0]        step_i,
  input logic [ADDR_W-1:0] ptr_data_i,
  input logic              ptr_ack_i,
  input logic [ADDR_W-1:0] ea_o,
  input logic              ea_valid_o,
  input logic              ptr_rd_o,
  input logic              busy_o,
  input logic              wb_en_o,
  input logic [ADDR_W-1:0] wb_data_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !ea_valid_o && !ptr_rd_o && !busy_o && !wb_en_o); // R1

  AST_IDLE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (mode_i != 3'd5) |=> ea_valid_o && !busy_o); // R5

  AST_PTR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (mode_i == 3'd5) |=> ptr_rd_o && busy_o && ea_o == $past(base_i)); // R6

  AST_PTR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && ptr_ack_i |=> ea_valid_o && !busy_o && ea_o == $past(ptr_data_i)); // R6

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ptr_ack_i |=> busy_o && ptr_rd_o && !ea_valid_o && $stable(ea_o)); // R7

  AST_WB_AUTO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> $past(start_i) && !$past(busy_o) && ($past(mode_i) inside {3'd6, 3'd7})); // R10

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && $past(mode_i) == 3'd6 |-> wb_data_o - ea_o == (ADDR_W'(1) << $past(step_i))); // R8

  AST_DEC_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && $past(mode_i) == 3'd7 |-> wb_data_o == ea_o && $past(base_i) - ea_o == (ADDR_W'(1) << $past(step_i))); // R9
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .base_i     (base_i),
  .step_i     (step_i),
  .ptr_data_i (ptr_data_i),
  .ptr_ack_i  (ptr_ack_i),
  .ea_o       (ea_o),
  .ea_valid_o (ea_valid_o),
  .ptr_rd_o   (ptr_rd_o),
  .busy_o     (busy_o),
  .wb_en_o    (wb_en_o),
  .wb_data_o  (wb_data_o)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam time         CLK_PERIOD = 10ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [2:0]        mode_i = '0;
  logic [ADDR_W-1:0] base_i = '0, index_i = '0, ptr_data_i = '0;
  logic [IMM_W-1:0]  imm_i = '0;
  logic [1:0]        step_i = '0;
  logic              ptr_ack_i = 1'b0;
  logic [ADDR_W-1:0] ea_o, wb_data_o;
  logic              ea_valid_o, ptr_rd_o, busy_o, wb_en_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ea_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] sx(input logic [IMM_W-1:0] v);
    return {{(ADDR_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] exp_ea(input logic [2:0] m, input logic [ADDR_W-1:0] b,
      input logic [ADDR_W-1:0] x, input logic [IMM_W-1:0] im, input logic [1:0] s);
    logic [ADDR_W-1:0] d = ADDR_W'(1) << s;
    case (m)
      3'd0: return b;
      3'd1: return sx(im);
      3'd2: return b + sx(im);
      3'd3: return b + x;
      3'd4: return sx(im) + b + x * d;
      3'd6: return b;
      3'd7: return b - d;
      default: return b;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return "R6";
    endcase
  endfunction

  // one non-indirect request, result checked one cycle later
  task automatic req_direct(input logic [2:0] m, input logic [ADDR_W-1:0] b,
      input logic [ADDR_W-1:0] x, input logic [IMM_W-1:0] im, input logic [1:0] s);
    logic auto_m = (m == 3'd6) || (m == 3'd7);
    logic [ADDR_W-1:0] d = ADDR_W'(1) << s;
    start_i = 1'b1; mode_i = m; base_i = b; index_i = x; imm_i = im; step_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R5", "ea_valid_o", ADDR_W'(ea_valid_o), 1);
    chk(req_of(m), "ea_o", ea_o, exp_ea(m, b, x, im, s));
    chk("R10", "wb_en_o", ADDR_W'(wb_en_o), ADDR_W'(auto_m));
    if (m == 3'd6) chk("R8", "wb_data_o", wb_data_o, b + d);
    if (m == 3'd7) chk("R9", "wb_data_o", wb_data_o, b - d);
    @(negedge clk_i);
    chk("R5", "ea_valid_o pulse", ADDR_W'(ea_valid_o), 0);
  endtask

  // memory-indirect request with a given wait before acknowledge
  task automatic req_ind(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] ptr, input int wait_n);
    start_i = 1'b1; mode_i = 3'd5; base_i = b; index_i = $urandom; imm_i = IMM_W'($urandom); step_i = 2'($urandom);
    @(negedge clk_i);
    chk("R6", "ptr_rd_o", ADDR_W'(ptr_rd_o), 1);
    chk("R6", "busy_o", ADDR_W'(busy_o), 1);
    chk("R6", "pointer address", ea_o, b);
    for (int i = 0; i < wait_n; i++) begin
      start_i = 1'b1; mode_i = 3'($urandom % 5); base_i = $urandom; // R7 stray requests
      @(negedge clk_i);
      chk("R7", "busy held", ADDR_W'(busy_o), 1);
      chk("R7", "no result", ADDR_W'(ea_valid_o), 0);
      chk("R7", "ea stable", ea_o, b);
      chk("R7", "no wb", ADDR_W'(wb_en_o), 0);
    end
    start_i = 1'b1; mode_i = 3'd0; base_i = ~ptr;
    ptr_ack_i = 1'b1; ptr_data_i = ptr;
    @(negedge clk_i);
    ptr_ack_i = 1'b0; ptr_data_i = $urandom; start_i = 1'b0;
    chk("R6", "busy after ack", ADDR_W'(busy_o), 0);
    chk("R6", "ea_valid_o", ADDR_W'(ea_valid_o), 1);
    chk("R6", "final address", ea_o, ptr);
    chk("R10", "wb_en_o", ADDR_W'(wb_en_o), 0);
    @(negedge clk_i);
    chk("R7", "stray start ignored", ADDR_W'(ea_valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk("R1", "ea_valid_o in reset", ADDR_W'(ea_valid_o), 0);
    chk("R1", "busy_o in reset", ADDR_W'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "ptr_rd_o after reset", ADDR_W'(ptr_rd_o), 0);
    chk("R1", "wb_en_o after reset", ADDR_W'(wb_en_o), 0);

    // directed corners
    req_direct(3'd0, 32'h1000_0000, 32'h5, 16'h7fff, 2'd0);
    req_direct(3'd1, 32'h0, 32'h0, 16'h8004, 2'd0);            // negative absolute
    req_direct(3'd2, 32'h0000_0010, 32'h0, 16'hfff0, 2'd0);    // disp -16 -> 0
    req_direct(3'd3, 32'hffff_fffc, 32'h8, 16'h0, 2'd0);       // wrap
    for (int s = 0; s < 4; s++) req_direct(3'd4, 32'h100, 32'h3, 16'hffff, 2'(s));
    req_direct(3'd6, 32'hffff_fff8, 32'h0, 16'h0, 2'd3);       // wrap on increment
    req_direct(3'd7, 32'h0000_0001, 32'h0, 16'h0, 2'd1);       // wrap on decrement
    req_ind(32'h2000, 32'hdead_beec, 0);
    req_ind(32'h3000, 32'h0000_0040, 5);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] m = 3'($urandom);
      if (m == 3'd5) req_ind($urandom, $urandom, int'($urandom % 6));
      else req_direct(m, $urandom, $urandom, IMM_W'($urandom), 2'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule